// File: doc/BRIEF.md
# Multi-Mode Serial Shift Register

This block is the byte-wide serial shifter of a peripheral-interface chip. It moves a data byte in or out over one serial data line, one bit per shift-clock period. A 3-bit mode input selects the direction and the clock source. The clock source is a timer underflow tick, the system clock, or an external clock pin. In one shift-out mode the shifter runs without stopping at the tick rate. With an internal source the block drives its own shift clock on `sclk_out`. With the external source it samples an external clock through a synchroniser chain.

Software writes or reads the data byte through a plain register port. Every access is taken in the cycle it is presented, so there is no back-pressure and no valid/ready handshake. An access also re-arms an eight-bit transfer. When a transfer ends, `done_flag` rises and stays high until the next access. The timer that makes the tick, the interrupt enable logic and the bus decoding sit outside the block.

Top module: `serial_shifter`

## Requirements
- R1: After reset, `rd_data` is 0x00, `done_flag` is 0, `sclk_out` is 1 and `ser_out` is 0.
- R2: The mode input `mode[2:0]` is decoded as follows:
  - 000: disabled.
  - 001: shift in on the tick.
  - 010: shift in on the system clock.
  - 011: shift in on the external clock.
  - 100: free-running shift out on the tick.
  - 101: shift out on the tick.
  - 110: shift out on the system clock.
  - 111: shift out on the external clock.
- R3: In every mode except 100, the transfer stops after eight shifts and `done_flag` goes to 1. After that, `rd_data` does not change until the next access.
- R4: A shift-out step moves the byte one place toward the MSB and copies the old bit 7 into bit 0. `ser_out` always shows bit 7 of the byte, so the MSB goes out first. After eight steps the byte is back to its starting value.
- R5: A shift-in step moves the byte one place toward the MSB and loads `ser_in` into bit 0. `ser_in` is sampled at the rising edge of the shift clock.
- R6: In mode 100 the shifting never stops and `done_flag` is never set.
- R7: With an internal source, `sclk_out` idles at 1. It falls on the first source strobe (a tick pulse, or any system-clock cycle) and rises on the next strobe, and the data shifts on that rise. With the external source, `sclk_out` stays at 1.
- R8: In external modes, `ext_clk_in` passes through SYNC_STAGES flops clocked by the system clock (default 2). A rising edge first sampled at clock edge k shifts the data at clock edge k+SYNC_STAGES.
- R9: A write (`reg_wr`=1) or a read (`reg_rd`=1) clears `done_flag` and restarts the eight-shift count. A write also loads `wr_data` into the byte. An access wins over a shift in the same cycle.
- R10: In mode 000 nothing shifts, `sclk_out` stays at 1 and `done_flag` is not set. A write still loads the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Shift mode, encoded as in R2 |
| reg_wr | input | 1 | Write strobe for the data byte |
| reg_rd | input | 1 | Read strobe for the data byte |
| wr_data | input | DATA_W | Byte to load on a write |
| rd_data | output | DATA_W | Current content of the shift register |
| tick | input | 1 | Timer underflow pulse, one cycle wide |
| ext_clk_in | input | 1 | External shift clock, asynchronous |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out (bit 7 of the byte) |
| sclk_out | output | 1 | Shift clock driven in internal-source modes |
| done_flag | output | 1 | Transfer-complete flag |

## Verification
Every mode is run with its own pattern:
- The system-clock modes check the two-cycle bit period.
- Sparse tick pulses check that `sclk_out` advances on strobes and not on cycles.
- A slow toggling external clock checks the synchroniser delay and shows that `sclk_out` stays high.

Constant `ser_in` levels (all ones, then all zeros) distinguish the shift-in path from the rotate path. A pseudo-random `ser_in` during shift-out shows that the input is ignored in that direction. Mid-transfer accesses, reads after completion, free-running runs past eight bits, and the disabled mode separate the stop, restart and no-flag rules.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TICK = 2'd1,
    SRC_SYS  = 2'd2,
    SRC_EXT  = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic     enabled;
    logic     dir_out;
    logic     free_run;
    clk_src_e src;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.enabled  = (m != 3'b000);
    d.dir_out  = m[2];
    d.free_run = (m == 3'b100);
    unique case (m[1:0])
      2'b00:   d.src = m[2] ? SRC_TICK : SRC_NONE;
      2'b01:   d.src = SRC_TICK;
      2'b10:   d.src = SRC_SYS;
      default: d.src = SRC_EXT;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/shf_sync.sv
module shf_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/shf_bitclk.sv
module shf_bitclk
  import shf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     run,
  input  logic     restart,
  input  logic     tick,
  input  logic     ext_lvl,
  output logic     shift_evt,
  output logic     sclk_out
);
  logic sclk_q;
  logic ext_prev;
  logic ext_rise;
  logic strobe;

  always_comb begin
    unique case (src)
      SRC_TICK: strobe = tick;
      SRC_SYS:  strobe = 1'b1;
      default:  strobe = 1'b0;
    endcase
  end

  assign ext_rise = ext_lvl & ~ext_prev;

  always_comb begin
    shift_evt = 1'b0;
    if (run && !restart) begin
      if (src == SRC_EXT) shift_evt = ext_rise;
      else                shift_evt = strobe & ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      ext_prev <= 1'b1;
    end else begin
      ext_prev <= ext_lvl;
      if (restart || !run) sclk_q <= 1'b1;
      else if (strobe)     sclk_q <= ~sclk_q;
    end
  end

  assign sclk_out = sclk_q;
endmodule

// File: rtl/shf_seq.sv
module shf_seq #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic shift_evt,
  input  logic free_run,
  output logic active,
  output logic done
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      active <= 1'b1;
      done   <= 1'b0;
    end else if (shift_evt && !free_run) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shf_data.sv
module shf_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_evt,
  input  logic              dir_out,
  input  logic              ser_in,
  output logic [DATA_W-1:0] data
);
  logic feed;

  assign feed = dir_out ? data[DATA_W-1] : ser_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data <= '0;
    else if (load)      data <= load_val;
    else if (shift_evt) data <= {data[DATA_W-2:0], feed};
  end
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  input  logic              ext_clk_in,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              sclk_out,
  output logic              done_flag
);
  mode_dec_t dec;
  logic      access;
  logic      active;
  logic      run;
  logic      ext_lvl;
  logic      shift_evt;

  assign dec    = decode_mode(mode);
  assign access = reg_wr | reg_rd;
  assign run    = dec.free_run | (active & dec.enabled);

  shf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk_in), .q(ext_lvl)
  );

  shf_bitclk u_bitclk (
    .clk(clk), .rst_n(rst_n), .src(dec.src), .run(run), .restart(access),
    .tick(tick), .ext_lvl(ext_lvl), .shift_evt(shift_evt), .sclk_out(sclk_out)
  );

  shf_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(access), .shift_evt(shift_evt),
    .free_run(dec.free_run), .active(active), .done(done_flag)
  );

  shf_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(reg_wr), .load_val(wr_data),
    .shift_evt(shift_evt), .dir_out(dec.dir_out), .ser_in(ser_in), .data(rd_data)
  );

  assign ser_out = rd_data[DATA_W-1];
endmodule

// File: rtl/serial_shifter_chk.sv
module serial_shifter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              sclk_out,
  input logic              done_flag,
  input logic              shift_evt
);
  // R9: any access clears the completion flag
  assert_access_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> !done_flag);

  // R9: write loads the byte
  assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (rd_data == $past(wr_data)));

  // R10: disabled mode keeps the clock high
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> sclk_out);

  // R6: free-running never sets the flag
  assert_free_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100 && !done_flag) |=> !done_flag);

  // R7: external source leaves the clock pin high
  assert_ext_sclk_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b11 && sclk_out) |=> sclk_out);

  // R4: shift-out rotates MSB into LSB
  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && mode[2] && !reg_wr) |=>
      (rd_data == {$past(rd_data[DATA_W-2:0]), $past(rd_data[DATA_W-1])}));

  // R3: a finished transfer holds its data
  assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && mode != 3'b100 && !reg_wr && !reg_rd) |=> $stable(rd_data));
endmodule

bind serial_shifter serial_shifter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .wr_data(wr_data), .rd_data(rd_data), .sclk_out(sclk_out),
  .done_flag(done_flag), .shift_evt(shift_evt)
);

// File: tb/tb_serial_shifter.sv
module tb_serial_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic       reg_wr = 0, reg_rd = 0, tick = 0, ext_clk_in = 1, ser_in = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       ser_out, sclk_out, done_flag;

  int compared = 0, mismatched = 0;
  int cyc = 0, tick_div = 0, ext_div = 0, ser_mode = 0; // 0 random, 1 ones, 2 zeros
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  // reference model state
  logic [7:0] m_sh = 0;
  bit m_flag = 0, m_active = 0, m_sclk = 1;
  int m_cnt = 0;
  bit q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shifter #(.DATA_W(8), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .ext_clk_in(ext_clk_in),
    .ser_in(ser_in), .ser_out(ser_out), .sclk_out(sclk_out), .done_flag(done_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 0; m_flag = 0; m_active = 0; m_sclk = 1; m_cnt = 0;
      q.delete();
      repeat (SYNC+1) q.push_back(1'b1);
    end else begin
      bit s_now, s_prev, en, free, ext, sys, run, evt, strobe;
      s_now  = q[q.size()-SYNC];
      s_prev = q[q.size()-SYNC-1];
      q.push_back(ext_clk_in);
      if (q.size() > SYNC+2) void'(q.pop_front());
      en   = (mode != 0);
      free = (mode == 3'b100);
      ext  = (mode[1:0] == 2'b11);
      sys  = (mode[1:0] == 2'b10);
      run  = free || (m_active && en);
      if (reg_wr || reg_rd) begin
        m_active = 1; m_cnt = 0; m_flag = 0; m_sclk = 1;
        if (reg_wr) m_sh = wr_data;
      end else if (!run) begin
        m_sclk = 1;
      end else begin
        evt = 0;
        if (ext) evt = s_now && !s_prev;
        else begin
          strobe = sys ? 1'b1 : tick;
          if (strobe) begin
            if (m_sclk) m_sclk = 0;
            else begin m_sclk = 1; evt = 1; end
          end
        end
        if (evt) begin
          m_sh = {m_sh[6:0], mode[2] ? m_sh[7] : ser_in};
          if (!free) begin
            m_cnt++;
            if (m_cnt == 8) begin m_cnt = 0; m_active = 0; m_flag = 1; end
          end
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check("R4 rd_data vs model", rd_data, m_sh);
    check("R4 ser_out vs model", ser_out, m_sh[7]);
    check("R7 sclk_out vs model", sclk_out, m_sclk);
    check("R3 done_flag vs model", done_flag, m_flag);
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk); #1;
      cyc++;
      reg_wr = 0; reg_rd = 0;
      tick = (tick_div != 0) && (cyc % tick_div == 0);
      if (ext_div != 0 && cyc % ext_div == 0) ext_clk_in = ~ext_clk_in;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser_in = (ser_mode == 1) ? 1'b1 : (ser_mode == 2) ? 1'b0 : lfsr[0];
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(posedge clk); #1;
    reg_wr = 1; wr_data = v; tick = 0;
  endtask

  task automatic rd();
    @(posedge clk); #1;
    reg_rd = 1; tick = 0;
  endtask

  task automatic at_neg(); @(negedge clk); #1; endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    at_neg();
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 done_flag", done_flag, 0);
    check("R1 sclk_out", sclk_out, 1);
    check("R1 ser_out", ser_out, 0);

    // R4/R7: system-clock shift out, random ser_in ignored
    mode = 3'b110; ser_mode = 0;
    wr(8'hA5); step(6); at_neg();
    check("R9 mid-transfer no flag", done_flag, 0);
    step(20); at_neg();
    check("R3 done after eight shifts", done_flag, 1);
    check("R4 rotated byte returns", rd_data, 8'hA5);
    step(10); at_neg();
    check("R3 stays stopped", rd_data, 8'hA5);
    // R9 read clears flag
    rd(); step(1); at_neg();
    check("R9 read clears flag", done_flag, 0);
    step(30); at_neg();
    check("R9 read restarted count", done_flag, 1);

    // R5: system-clock shift in, constant ones
    mode = 3'b010; ser_mode = 1;
    wr(8'h00); step(20); at_neg();
    check("R5 shift in ones", rd_data, 8'hFF);
    check("R5 done", done_flag, 1);

    // R5/R2: tick shift in, zeros, sparse ticks
    mode = 3'b001; ser_mode = 2; tick_div = 3;
    wr(8'hFF); step(10); at_neg();
    check("R2 tick mode not yet done", done_flag, 0);
    step(50); at_neg();
    check("R5 tick shift in zeros", rd_data, 8'h00);
    check("R2 tick mode done", done_flag, 1);

    // R2: tick shift out
    mode = 3'b101; ser_mode = 0; tick_div = 4;
    wr(8'h3C); step(20); at_neg();
    check("R2 tick out not done", done_flag, 0);
    step(60); at_neg();
    check("R2 tick out done", done_flag, 1);
    check("R4 tick out byte", rd_data, 8'h3C);

    // R8/R7: external clock shift out
    mode = 3'b111; tick_div = 1; ext_div = 3;
    wr(8'hC3); step(20); at_neg();
    check("R7 ext sclk high", sclk_out, 1);
    step(60); at_neg();
    check("R8 ext done", done_flag, 1);
    check("R8 ext byte", rd_data, 8'hC3);

    // R8: external shift in with ones
    mode = 3'b011; ser_mode = 1;
    wr(8'h00); step(80); at_neg();
    check("R8 ext shift in", rd_data, 8'hFF);

    // R6: free running
    mode = 3'b100; ser_mode = 0; ext_div = 0; tick_div = 1;
    wr(8'h01); step(60); at_neg();
    check("R6 no flag in free run", done_flag, 0);
    step(7); at_neg();
    check("R6 still no flag", done_flag, 0);

    // R10: disabled mode
    mode = 3'b000;
    wr(8'h5A); step(20); at_neg();
    check("R10 byte held", rd_data, 8'h5A);
    check("R10 no flag", done_flag, 0);
    check("R10 sclk high", sclk_out, 1);

    step(5);
    finish_run();
  end
endmodule